// File: doc/BRIEF.md
# Slave Port Arbitration Scheduler

This block serves one slave port of a multi-master bus matrix that uses AHB-style transfer signalling. It watches the transfer on the port and decides on which cycles the slave may be handed to another master. Between those points, bursts stay whole. At each such point it picks, by fixed priority, one of the masters that are asking for the slave, and it holds that one-hot grant until the next point.

Points come from the traffic itself: an idle slave, a single transfer, or the final beat of a burst. A fixed-length burst's final beat is found by counting beats against the burst size. An undefined-length burst ends when an external break generator pulses. A programmable slot timer covers the remaining case of long ownership. It reloads at every point and counts down each clock. When it runs out, the current owner loses the slave on its next completed beat, even in the middle of a burst or in a chain of back-to-back undefined-length bursts. A limit of zero switches the timer off.

Top module: `slot_arb_sched`

## Requirements
- R1: With `hready` high, a cycle whose transfer code is IDLE (`htrans` = 0) is an arbitration point (`arb_point` = 1). So is any cycle in which no master holds the grant (`grant` all zero).
- R2: With `hready` high, a NONSEQ transfer (`htrans` = 2) whose burst code is SINGLE (`hburst` = 0) is an arbitration point.
- R3: A fixed-length burst has burst code 2/3 for 4 beats, 4/5 for 8 beats and 6/7 for 16 beats. It is an arbitration point only on its last beat. Beats are counted from the NONSEQ beat and on each NONSEQ or SEQ (`htrans` = 3) cycle with `hready` high. BUSY cycles (`htrans` = 1) are neither counted nor points.
- R4: An undefined-length burst (`hburst` = 1) has an arbitration point only on a NONSEQ or SEQ beat during which `ulb_end` is high.
- R5: At every arbitration point, the clock edge loads the slot timer with `slot_limit`. After that it falls by one each clock until it reaches zero. With a nonzero limit L loaded at the edge ending cycle k, cycle k+L+1 and later cycles are arbitration points whenever `hready` is high, even inside a burst. This holds for back-to-back bursts too.
- R6: A `slot_limit` of zero at the loading point disables the timer-based break until the next point.
- R7: No cycle with `hready` low is an arbitration point, whatever its other conditions. A pending break therefore waits for the current beat to complete.
- R8: On the clock edge that ends an arbitration point with at least one request, `grant` becomes one-hot on the requesting master with the lowest index. Bit i of `req` and of `grant` belong to master i.
- R9: `grant` changes only on the edge ending an arbitration point. At a point with no request it keeps its previous value.
- R10: Reset (active-low `rst_n`) clears `grant` to all zero and disables the slot timer.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| req | input | NUM_MASTERS | Per-master request for this slave |
| htrans | input | 2 | Transfer code of the current cycle: 0 IDLE, 1 BUSY, 2 NONSEQ, 3 SEQ |
| hburst | input | 3 | Burst code of the current transfer |
| hready | input | 1 | High when the current beat completes this cycle |
| ulb_end | input | 1 | Break pulse for undefined-length bursts from the burst break generator |
| slot_limit | input | SLOT_W | Slot cycle limit, sampled at arbitration points; 0 disables |
| grant | output | NUM_MASTERS | One-hot (or all-zero) grant of the slave |
| arb_point | output | 1 | High in a cycle whose closing edge may re-arbitrate |

## Verification
The stimulus sets each source of an arbitration point against one that must not fire. Idle and single transfers are separated from the inner beats of 4- and 8-beat bursts that are interrupted by BUSY and wait states. A break pulse on an undefined-length burst is separated from the same burst without it. A stream of undefined-length bursts with no idle cycles between them shows that only the slot timer can break the stream, that its expiry is delayed by a low `hready`, and that a zero limit keeps the stream unbroken. Request masks that differ between cycles show that the lowest-index requester wins only at points, and that a higher-priority request arriving mid-burst has no effect until the next point.

// File: rtl/slot_arb_pkg.sv
// Package: shared transfer/burst encodings and burst length helper for the
// slave port arbitration scheduler. Assumes AHB-style 2-bit transfer and
// 3-bit burst codes.
package slot_arb_pkg;

    typedef enum logic [1:0] {
        TR_IDLE   = 2'd0,
        TR_BUSY   = 2'd1,
        TR_NONSEQ = 2'd2,
        TR_SEQ    = 2'd3
    } trans_e;

    typedef enum logic [2:0] {
        BT_SINGLE = 3'd0,
        BT_INCR   = 3'd1,
        BT_WRAP4  = 3'd2,
        BT_INCR4  = 3'd3,
        BT_WRAP8  = 3'd4,
        BT_INCR8  = 3'd5,
        BT_WRAP16 = 3'd6,
        BT_INCR16 = 3'd7
    } burst_e;

    localparam int MAX_FIXED_BEATS = 16;
    localparam int BEAT_W          = $clog2(MAX_FIXED_BEATS);

    // Number of beats in a fixed-length burst, zero for SINGLE and INCR.
    function automatic logic [BEAT_W:0] fixed_beats(input burst_e bt);
        case (bt)
            BT_WRAP4,  BT_INCR4:  fixed_beats = (BEAT_W+1)'(4);
            BT_WRAP8,  BT_INCR8:  fixed_beats = (BEAT_W+1)'(8);
            BT_WRAP16, BT_INCR16: fixed_beats = (BEAT_W+1)'(16);
            default:              fixed_beats = '0;
        endcase
    endfunction

endpackage

// File: rtl/sas_beat_tracker.sv
// Beat tracker: counts the beats of the current burst and flags natural
// boundaries (idle, single transfer, last beat of a fixed burst, break pulse
// of an undefined-length burst). Assumes a burst begins with a NONSEQ beat.
// The boundary flag is not qualified by hready; the top does that.
module sas_beat_tracker
    import slot_arb_pkg::*;
(
    input  logic       clk,
    input  logic       rst_n,
    input  logic [1:0] htrans,
    input  logic [2:0] hburst,
    input  logic       hready,
    input  logic       ulb_end,
    output logic       boundary
);

    trans_e            tr;
    burst_e            bt;
    logic              active;
    logic              is_fixed;
    logic [BEAT_W-1:0] beat_q;
    logic [BEAT_W-1:0] cur_idx;
    logic [BEAT_W:0]   len;
    logic              last_fixed;

    assign tr     = trans_e'(htrans);
    assign bt     = burst_e'(hburst);
    assign active = (tr == TR_NONSEQ) || (tr == TR_SEQ);
    assign len    = fixed_beats(bt);
    assign is_fixed = (len != '0);

    // Index of the beat on the bus: zero on NONSEQ, else the running count.
    always_comb begin
        cur_idx = (tr == TR_NONSEQ) ? '0 : beat_q;
    end

    // Advance the beat count on every completed data beat.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            beat_q <= '0;
        end else if (active && hready) begin
            beat_q <= cur_idx + 1'b1;
        end
    end

    assign last_fixed = is_fixed && ({1'b0, cur_idx} == (len - 1'b1));

    // Combine the natural boundary conditions.
    always_comb begin
        boundary = (tr == TR_IDLE)
                 || (active && (bt == BT_SINGLE))
                 || (active && last_fixed)
                 || (active && (bt == BT_INCR) && ulb_end);
    end

endmodule

// File: rtl/sas_slot_timer.sv
// Slot timer: reloads from the programmed limit at each arbitration point and
// counts down every clock. Flags expiry once it reaches zero, unless the
// limit loaded was zero, which disables it.
module sas_slot_timer #(
    parameter int SLOT_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              load,
    input  logic [SLOT_W-1:0] limit,
    output logic              expired
);

    logic [SLOT_W-1:0] cnt_q;
    logic              en_q;

    // Reload at a point, otherwise count down to zero and stop.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cnt_q <= '0;
            en_q  <= 1'b0;
        end else if (load) begin
            cnt_q <= limit;
            en_q  <= (limit != '0);
        end else if (cnt_q != '0) begin
            cnt_q <= cnt_q - 1'b1;
        end
    end

    assign expired = en_q && (cnt_q == '0);

endmodule

// File: rtl/sas_prio_pick.sv
// Fixed-priority picker: returns a one-hot vector of the lowest-index active
// request and whether any request is active. Pure combinational logic.
module sas_prio_pick #(
    parameter int NUM_MASTERS = 4
) (
    input  logic [NUM_MASTERS-1:0] req,
    output logic [NUM_MASTERS-1:0] pick,
    output logic                   any
);

    logic [NUM_MASTERS-1:0] blocked;

    assign blocked[0] = 1'b0;

    genvar g;
    generate
        for (g = 1; g < NUM_MASTERS; g++) begin : g_chain
            assign blocked[g] = blocked[g-1] | req[g-1];
        end
    endgenerate

    assign pick = req & ~blocked;
    assign any  = |req;

endmodule

// File: rtl/slot_arb_sched.sv
// Slave port arbitration scheduler (top). Decides the cycles on which the
// slave may change owner and grants it by fixed priority at those cycles.
// Assumes the transfer signals describe the currently granted master's
// traffic on this port. Reset is synchronous and active-low.
module slot_arb_sched #(
    parameter int NUM_MASTERS = 4,
    parameter int SLOT_W      = 8
) (
    input  logic                   clk,
    input  logic                   rst_n,
    input  logic [NUM_MASTERS-1:0] req,
    input  logic [1:0]             htrans,
    input  logic [2:0]             hburst,
    input  logic                   hready,
    input  logic                   ulb_end,
    input  logic [SLOT_W-1:0]      slot_limit,
    output logic [NUM_MASTERS-1:0] grant,
    output logic                   arb_point
);

    logic                   boundary;
    logic                   slot_expired;
    logic                   unowned;
    logic [NUM_MASTERS-1:0] pick;
    logic                   any_req;

    sas_beat_tracker u_beats (
        .clk      (clk),
        .rst_n    (rst_n),
        .htrans   (htrans),
        .hburst   (hburst),
        .hready   (hready),
        .ulb_end  (ulb_end),
        .boundary (boundary)
    );

    sas_slot_timer #(.SLOT_W(SLOT_W)) u_slot (
        .clk     (clk),
        .rst_n   (rst_n),
        .load    (arb_point),
        .limit   (slot_limit),
        .expired (slot_expired)
    );

    sas_prio_pick #(.NUM_MASTERS(NUM_MASTERS)) u_pick (
        .req  (req),
        .pick (pick),
        .any  (any_req)
    );

    assign unowned = (grant == '0);

    // A point needs a completed beat plus a boundary, no owner, or expiry.
    always_comb begin
        arb_point = hready && (boundary || unowned || slot_expired);
    end

    // Update the grant at points that have at least one request.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            grant <= '0;
        end else if (arb_point && any_req) begin
            grant <= pick;
        end
    end

endmodule

// File: rtl/slot_arb_sched_chk.sv
// Checker for the slave port arbitration scheduler: temporal properties on
// the top module's ports, attached by bind.
module slot_arb_sched_chk #(
    parameter int NUM_MASTERS = 4
) (
    input logic                   clk,
    input logic                   rst_n,
    input logic [NUM_MASTERS-1:0] req,
    input logic [1:0]             htrans,
    input logic [2:0]             hburst,
    input logic                   hready,
    input logic [NUM_MASTERS-1:0] grant,
    input logic                   arb_point
);

    AST_IDLE_IS_POINT: assert property (@(posedge clk) disable iff (!rst_n)
        (htrans == 2'd0 && hready) |-> arb_point); // R1

    AST_SINGLE_IS_POINT: assert property (@(posedge clk) disable iff (!rst_n)
        (htrans == 2'd2 && hburst == 3'd0 && hready) |-> arb_point); // R2

    AST_NO_POINT_WHILE_WAIT: assert property (@(posedge clk) disable iff (!rst_n)
        !hready |-> !arb_point); // R7

    AST_GRANT_TO_REQUESTER: assert property (@(posedge clk) disable iff (!rst_n)
        (arb_point && req != '0) |=> ((grant & $past(req)) != '0)); // R8

    AST_GRANT_ONEHOT: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(grant)); // R8

    AST_GRANT_HELD_OFF_POINT: assert property (@(posedge clk) disable iff (!rst_n)
        !arb_point |=> $stable(grant)); // R9

    AST_GRANT_HELD_NO_REQ: assert property (@(posedge clk) disable iff (!rst_n)
        (arb_point && req == '0) |=> $stable(grant)); // R9

endmodule

bind slot_arb_sched slot_arb_sched_chk #(.NUM_MASTERS(NUM_MASTERS)) chk_i (
    .clk       (clk),
    .rst_n     (rst_n),
    .req       (req),
    .htrans    (htrans),
    .hburst    (hburst),
    .hready    (hready),
    .grant     (grant),
    .arb_point (arb_point)
);

// File: tb/slot_arb_sched_tb_top.sv
// Bench: a vector table walked one cycle per row, then directed reset and
// no-owner checks. Inputs change at the falling edge; arb_point is checked
// before the rising edge and grant just after it.
module slot_arb_sched_tb_top;

    localparam int CLK_PERIOD = 10;
    localparam int NM         = 4;
    localparam int SW         = 8;
    localparam int NROWS      = 33;

    logic          clk = 1'b0;
    logic          rst_n;
    logic [NM-1:0] req;
    logic [1:0]    htrans;
    logic [2:0]    hburst;
    logic          hready;
    logic          ulb_end;
    logic [SW-1:0] slot_limit;
    logic [NM-1:0] grant;
    logic          arb_point;

    int n_checks = 0;
    int n_fail   = 0;
    bit finished = 0;

    always #(CLK_PERIOD/2) clk = ~clk;

    slot_arb_sched #(.NUM_MASTERS(NM), .SLOT_W(SW)) dut_i (
        .clk        (clk),
        .rst_n      (rst_n),
        .req        (req),
        .htrans     (htrans),
        .hburst     (hburst),
        .hready     (hready),
        .ulb_end    (ulb_end),
        .slot_limit (slot_limit),
        .grant      (grant),
        .arb_point  (arb_point)
    );

    // Row: {rid[4], req[4], htrans[2], hburst[3], hready, ulb_end, limit[8], exp_point, exp_grant[4]}
    localparam logic [27:0] VEC [0:NROWS-1] = '{
        {4'd1,  4'b0000, 2'd0, 3'd0, 1'b1, 1'b0, 8'd0, 1'b1, 4'b0000}, // R1 idle, no request
        {4'd8,  4'b0100, 2'd0, 3'd0, 1'b1, 1'b0, 8'd0, 1'b1, 4'b0100}, // R8 single requester
        {4'd2,  4'b0110, 2'd2, 3'd0, 1'b1, 1'b0, 8'd0, 1'b1, 4'b0010}, // R2 single, lowest wins
        {4'd7,  4'b0101, 2'd2, 3'd3, 1'b0, 1'b0, 8'd0, 1'b0, 4'b0010}, // R7 wait on first beat
        {4'd3,  4'b0101, 2'd2, 3'd3, 1'b1, 1'b0, 8'd0, 1'b0, 4'b0010}, // R3 beat 0 of 4
        {4'd3,  4'b0101, 2'd3, 3'd3, 1'b1, 1'b0, 8'd0, 1'b0, 4'b0010}, // R3 beat 1
        {4'd3,  4'b0101, 2'd1, 3'd3, 1'b1, 1'b0, 8'd0, 1'b0, 4'b0010}, // R3 BUSY not counted
        {4'd3,  4'b0101, 2'd3, 3'd3, 1'b1, 1'b0, 8'd0, 1'b0, 4'b0010}, // R3 beat 2
        {4'd7,  4'b0101, 2'd3, 3'd3, 1'b0, 1'b0, 8'd0, 1'b0, 4'b0010}, // R7 last beat waiting
        {4'd3,  4'b0101, 2'd3, 3'd3, 1'b1, 1'b0, 8'd0, 1'b1, 4'b0001}, // R3 last beat completes
        {4'd4,  4'b1001, 2'd2, 3'd1, 1'b1, 1'b0, 8'd0, 1'b0, 4'b0001}, // R4 undefined, no pulse
        {4'd4,  4'b1001, 2'd3, 3'd1, 1'b1, 1'b0, 8'd0, 1'b0, 4'b0001}, // R4
        {4'd7,  4'b1001, 2'd3, 3'd1, 1'b0, 1'b1, 8'd0, 1'b0, 4'b0001}, // R7 pulse during wait
        {4'd4,  4'b1001, 2'd3, 3'd1, 1'b1, 1'b1, 8'd2, 1'b1, 4'b0001}, // R4 pulse, load limit 2
        {4'd5,  4'b1000, 2'd2, 3'd1, 1'b1, 1'b0, 8'd2, 1'b0, 4'b0001}, // R5 back-to-back burst
        {4'd5,  4'b1000, 2'd3, 3'd1, 1'b1, 1'b0, 8'd2, 1'b0, 4'b0001}, // R5
        {4'd5,  4'b1000, 2'd3, 3'd1, 1'b1, 1'b0, 8'd2, 1'b1, 4'b1000}, // R5 slot expiry breaks
        {4'd5,  4'b1001, 2'd3, 3'd1, 1'b1, 1'b0, 8'd0, 1'b0, 4'b1000}, // R5 reloaded 2
        {4'd5,  4'b1001, 2'd3, 3'd1, 1'b1, 1'b0, 8'd0, 1'b0, 4'b1000}, // R5
        {4'd7,  4'b1001, 2'd3, 3'd1, 1'b0, 1'b0, 8'd0, 1'b0, 4'b1000}, // R7 expiry waits for ready
        {4'd5,  4'b1001, 2'd3, 3'd1, 1'b1, 1'b0, 8'd0, 1'b1, 4'b0001}, // R5 break, load zero
        {4'd6,  4'b1000, 2'd3, 3'd1, 1'b1, 1'b0, 8'd0, 1'b0, 4'b0001}, // R6 timer off
        {4'd6,  4'b1000, 2'd3, 3'd1, 1'b1, 1'b0, 8'd0, 1'b0, 4'b0001}, // R6
        {4'd6,  4'b1000, 2'd3, 3'd1, 1'b1, 1'b0, 8'd0, 1'b0, 4'b0001}, // R6
        {4'd6,  4'b1000, 2'd3, 3'd1, 1'b1, 1'b0, 8'd0, 1'b0, 4'b0001}, // R6
        {4'd3,  4'b0010, 2'd2, 3'd4, 1'b1, 1'b0, 8'd0, 1'b0, 4'b0001}, // R3 8-beat wrap, beat 0
        {4'd3,  4'b0010, 2'd3, 3'd4, 1'b1, 1'b0, 8'd0, 1'b0, 4'b0001}, // R3 beat 1
        {4'd3,  4'b0010, 2'd3, 3'd4, 1'b1, 1'b0, 8'd0, 1'b0, 4'b0001}, // R3 beat 2
        {4'd3,  4'b0010, 2'd3, 3'd4, 1'b1, 1'b0, 8'd0, 1'b0, 4'b0001}, // R3 beat 3
        {4'd3,  4'b0010, 2'd3, 3'd4, 1'b1, 1'b0, 8'd0, 1'b0, 4'b0001}, // R3 beat 4
        {4'd3,  4'b0010, 2'd3, 3'd4, 1'b1, 1'b0, 8'd0, 1'b0, 4'b0001}, // R3 beat 5
        {4'd3,  4'b0010, 2'd3, 3'd4, 1'b1, 1'b0, 8'd0, 1'b0, 4'b0001}, // R3 beat 6
        {4'd3,  4'b0010, 2'd3, 3'd4, 1'b1, 1'b0, 8'd0, 1'b1, 4'b0010}  // R3 beat 7 is last
    };

    task automatic check(input string tag, input string what, input int act, input int exp);
        n_checks++;
        if (act != exp) begin
            n_fail++;
            $display("FAIL %s %s: actual %0h expected %0h", tag, what, act, exp);
        end
    endtask

    task automatic run_row(input int i);
        logic [27:0] v;
        string       tag;
        v = VEC[i];
        @(negedge clk);
        req        = v[23:20];
        htrans     = v[19:18];
        hburst     = v[17:15];
        hready     = v[14];
        ulb_end    = v[13];
        slot_limit = v[12:5];
        tag = $sformatf("R%0d row %0d", v[27:24], i);
        #1;
        check(tag, "arb_point", int'(arb_point), int'(v[4]));
        @(posedge clk);
        #1;
        check(tag, "grant", int'(grant), int'(v[3:0]));
    endtask

    task automatic summary();
        $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
    endtask

    initial begin
        rst_n      = 1'b0;
        req        = '0;
        htrans     = 2'd0;
        hburst     = 3'd0;
        hready     = 1'b1;
        ulb_end    = 1'b0;
        slot_limit = '0;
        repeat (3) @(posedge clk);
        #1;
        check("R10", "grant in reset", int'(grant), 0);
        @(negedge clk);
        rst_n = 1'b1;

        for (int i = 0; i < NROWS; i++) begin
            run_row(i);
        end

        // R10: reset mid-run clears an existing grant.
        @(negedge clk);
        rst_n   = 1'b0;
        req     = 4'b0100;
        htrans  = 2'd3;
        hburst  = 3'd1;
        @(posedge clk);
        #1;
        check("R10", "grant after reset", int'(grant), 0);

        // R1: with no owner, even a mid-burst beat is a point.
        @(negedge clk);
        rst_n = 1'b1;
        #1;
        check("R1", "arb_point without owner", int'(arb_point), 1);
        @(posedge clk);
        #1;
        check("R8", "grant from unowned", int'(grant), 4'b0100);

        // R9: higher-priority request mid-burst is ignored off a point.
        @(negedge clk);
        req = 4'b0001;
        #1;
        check("R9", "arb_point mid-burst", int'(arb_point), 0);
        @(posedge clk);
        #1;
        check("R9", "grant held mid-burst", int'(grant), 4'b0100);

        summary();
        finished = 1;
        $finish;
    end

    initial begin
        #(CLK_PERIOD * 5000);
        if (!finished) begin
            n_checks++;
            n_fail++;
            $display("FAIL watchdog: actual timeout expected completion");
            summary();
            $finish;
        end
    end

endmodule